// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block produces the address sequence for a four-beat burst into a pipelined synchronous memory. A start address is captured when either of two start strobes is asserted. On every later cycle the two least significant address bits step through the burst while the upper bits stay at their captured value. An active-low advance input moves the burst forward one beat when low and holds the current beat when high.

Two beat orders are supported. The mode input selects between them when a burst starts. The interleaved order XORs the start offset with the beat number. The linear order adds the beat number to the start offset and wraps modulo four. After the fourth beat the sequence returns to the start offset and carries on if advancing continues. The memory array and chip-select decoding sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and in the first cycle after it, `intAddr` is all zeros.
- R2: When `startProc` or `startCache` is high at a rising clock edge, `intAddr` equals the `extAddr` sampled at that edge from just after the edge onward. Each strobe alone is enough.
- R3: Between burst starts, the bits of `intAddr` above bit 1 keep the value captured at the start, whatever `extAddr` does.
- R4: With `modeSel` = 1 at the start, the low two bits follow start XOR beat. From 00: 00,01,10,11. From 01: 01,00,11,10. From 10: 10,11,00,01. From 11: 11,10,01,00.
- R5: With `modeSel` = 0 at the start, the low two bits follow (start + beat) mod 4.
- R6: With no strobe high, `advanceN` = 1 at an edge leaves `intAddr` unchanged. `advanceN` = 0 moves it to the next beat.
- R7: A strobe has priority over `advanceN` = 0 in the same cycle: the new address is loaded and the beat does not step.
- R8: After the fourth beat, a further advance returns the low bits to the start offset, and the sequence repeats.
- R9: `modeSel` is sampled only at a burst start. Changing it during a burst does not change the order until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | Burst order: 1 interleaved, 0 linear; sampled at burst start |
| startProc | input | 1 | Burst start strobe, first source, active high |
| startCache | input | 1 | Burst start strobe, second source, active high |
| advanceN | input | 1 | 0 steps to the next beat, 1 holds the current beat |
| extAddr | input | ADDR_W (18) | External start address |
| intAddr | output | ADDR_W (18) | Current internal burst address |

## Verification
A corrupted beat counter or captured start offset shows up in the low two bits of `intAddr` in the cycle right after the edge where the fault occurs. Bad upper-bit capture is visible right after the start edge, and it persists for the whole burst. A wrongly latched order only appears at the second beat, because both orders agree at beat zero, so every burst is run through at least two beats. A missed wrap only appears at the fifth beat, so each burst runs one beat past its length.

// File: rtl/burst_gen_pkg.sv
package burst_gen_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture external address, restart beat count
    logic step;  // move to the next beat
  } burst_ctrl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_gen_pkg::*;
(
  input  logic        startProc,
  input  logic        startCache,
  input  logic        advanceN,
  output burst_ctrl_t ctrl
);
  // A start strobe wins over advance in the same cycle
  always_comb begin
    ctrl.load = startProc | startCache;
    ctrl.step = ~ctrl.load & ~advanceN;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_ctrl_t       ctrl,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] intAddr
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BURST_W-1:0] startQ;
  logic [BURST_W-1:0] beatQ;
  logic               interleaveQ;
  logic [BURST_W-1:0] xorLow;
  logic [BURST_W-1:0] addLow;
  logic [BURST_W-1:0] lowAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upperQ      <= '0;
      startQ      <= '0;
      beatQ       <= '0;
      interleaveQ <= 1'b1;
    end else if (ctrl.load) begin
      upperQ      <= extAddr[ADDR_W-1:BURST_W];
      startQ      <= extAddr[BURST_W-1:0];
      beatQ       <= '0;
      interleaveQ <= modeSel;
    end else if (ctrl.step) begin
      beatQ       <= beatQ + 1'b1;  // wraps naturally after the last beat
    end
  end

  // Interleaved order: one XOR per sequenced bit
  for (genvar b = 0; b < BURST_W; b++) begin : g_xorBit
    assign xorLow[b] = startQ[b] ^ beatQ[b];
  end

  // Linear order: modular add of the beat count
  assign addLow = startQ + beatQ;

  assign lowAddr = interleaveQ ? xorLow : addLow;
  assign intAddr = {upperQ, lowAddr};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeSel,
  input  logic              startProc,
  input  logic              startCache,
  input  logic              advanceN,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] intAddr
);
  burst_ctrl_t ctrl;

  burst_ctrl u_ctrl (
    .startProc (startProc),
    .startCache(startCache),
    .advanceN  (advanceN),
    .ctrl      (ctrl)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .modeSel(modeSel),
    .extAddr(extAddr),
    .intAddr(intAddr)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startProc,
  input logic              startCache,
  input logic              advanceN,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] intAddr
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (startProc || startCache) |=> (intAddr == $past(extAddr))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!startProc && !startCache && advanceN) |=> $stable(intAddr)); // R6

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!startProc && !startCache) |=>
      (intAddr[ADDR_W-1:BURST_W] == $past(intAddr[ADDR_W-1:BURST_W]))); // R3

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!startProc && !startCache && !advanceN) |=>
      (intAddr[BURST_W-1:0] != $past(intAddr[BURST_W-1:0]))); // R4

  AST_PRIORITY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (startCache && !advanceN) |=> (intAddr == $past(extAddr))); // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startProc (startProc),
  .startCache(startCache),
  .advanceN  (advanceN),
  .extAddr   (extAddr),
  .intAddr   (intAddr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              modeSel = 1'b1;
  logic              startProc = 1'b0;
  logic              startCache = 1'b0;
  logic              advanceN = 1'b1;
  logic [ADDR_W-1:0] extAddr = '0;
  logic [ADDR_W-1:0] intAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [ADDR_W-1:0] expQ[$];
  string             reqQ[$];

  // bench model state
  logic [ADDR_W-3:0] mUpper = '0;
  logic [1:0]        mStart = '0;
  int                mBeat = 0;
  logic              mMode = 1'b1;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .startProc(startProc),
    .startCache(startCache), .advanceN(advanceN), .extAddr(extAddr), .intAddr(intAddr)
  );

  // Interleaved order as listed in R4
  function automatic logic [1:0] ilvBeat(logic [1:0] s, int k);
    case (s)
      2'd0: case (k % 4) 0: return 2'd0; 1: return 2'd1; 2: return 2'd2; default: return 2'd3; endcase
      2'd1: case (k % 4) 0: return 2'd1; 1: return 2'd0; 2: return 2'd3; default: return 2'd2; endcase
      2'd2: case (k % 4) 0: return 2'd2; 1: return 2'd3; 2: return 2'd0; default: return 2'd1; endcase
      default: case (k % 4) 0: return 2'd3; 1: return 2'd2; 2: return 2'd1; default: return 2'd0; endcase
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] modelAddr();
    logic [1:0] low;
    if (mMode) low = ilvBeat(mStart, mBeat);
    else       low = 2'((int'(mStart) + mBeat) % 4);
    return {mUpper, low};
  endfunction

  task automatic check(logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: intAddr=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs, push the expected result
  task automatic drive(bit p, bit c, bit advN, bit mode, logic [ADDR_W-1:0] ext, string req);
    @(negedge clk);
    startProc = p; startCache = c; advanceN = advN; modeSel = mode; extAddr = ext;
    if (p || c) begin
      mUpper = ext[ADDR_W-1:2]; mStart = ext[1:0]; mBeat = 0; mMode = mode;
    end else if (!advN) begin
      mBeat++;
    end
    expQ.push_back(modelAddr());
    reqQ.push_back(req);
  endtask

  // Monitor: compare just after each edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic [ADDR_W-1:0] e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      check(intAddr, e, r);
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: intAddr=%h expected=done", intAddr);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2 check(intAddr, '0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2 check(intAddr, '0, "R1 after reset");

    // R4/R5/R8: every start value in both modes, run one beat past wrap
    for (int m = 1; m >= 0; m--) begin
      for (int s = 0; s < 4; s++) begin
        logic [ADDR_W-1:0] a;
        a = {16'h2A5C ^ 16'(s * 16'h1111 + m), 2'(s)};
        drive(s[0], !s[0], 1'b1, 1'(m), a, "R2 load");
        for (int k = 1; k <= 5; k++) begin
          // extAddr wiggles without a strobe: must be ignored (R3)
          drive(1'b0, 1'b0, 1'b0, 1'(m), ~a, m ? "R4 R8 R3 interleave" : "R5 R8 R3 linear");
        end
      end
    end

    // R6: suspend holds the beat
    drive(1'b1, 1'b0, 1'b1, 1'b0, 18'h1_2342, "R2 load");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 18'h0, "R5 step");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 18'h3FFFF, "R6 hold");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 18'h3FFFF, "R6 hold");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 18'h0, "R6 resume");

    // R7: strobe beats advance in the same cycle
    drive(1'b0, 1'b1, 1'b0, 1'b1, 18'h2_5553, "R7 cache strobe priority");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 18'h0, "R7 step after load");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 18'h0_ABC1, "R7 proc strobe priority");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 18'h1_0002, "R7 both strobes");

    // R9: mode change mid-burst ignored until next load
    drive(1'b1, 1'b0, 1'b1, 1'b1, 18'h0_0F01, "R2 load interleave");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 18'h0, "R9 mode flipped mid burst");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 18'h0, "R9 mode flipped mid burst");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 18'h0_0F01, "R9 reload linear");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 18'h0, "R9 mode flipped mid burst");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 18'h0, "R9 mode flipped mid burst");

    @(negedge clk);
    startProc = 1'b0; startCache = 1'b0; advanceN = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule